// File: doc/BRIEF.md
# Line-Clocked Multichannel PWM Dimmer

This block generates a bank of PWM dimming gates for LED current sinks. Its timebase is not the system clock: a line-rate sync input acts as the counting clock, and a frame-rate sync input realigns that count at the start of every frame. Both sync inputs arrive asynchronously. Each input is resynchronised into the system clock domain, and only its rising edges are used.

A single shared counter advances by one on each line-sync rising edge. It wraps at a common programmable period, so a frame can hold several PWM periods. It returns to zero on every frame-sync rising edge. Each channel has its own delay, on-time and enable. A channel is lit while the shared count lies inside its window. The outputs gate the sinks and also qualify fault detection. For that reason a disabled channel, or the bank before the first frame sync, is held dark.

The configuration inputs are plain levels and have no handshake, because the block never applies back-pressure. A new value takes effect on the next system clock.

Top module: `sync_pwm_dimmer`

## Requirements
- R1: After reset every dim output is low. All outputs stay low, whatever the line-sync activity, until the first frame-sync rising edge is seen.
- R2: A frame-sync rising edge sets the shared count to 0. Each later line-sync rising edge adds one, so k line edges after a frame sync the count is k (before any wrap).
- R3: While the bank is running, channel i is high exactly when delay_i <= count < delay_i + on_i. delay_i occupies bits [i*CNT_W +: CNT_W] of delay_cfg, and on_i occupies the same bits of on_cfg.
- R4: When a line edge would take the count to the period value, the count goes to 0 instead. The count therefore runs 0 to period-1 repeatedly within one frame.
- R5: A channel whose on-time is 0 stays low.
- R6: A channel whose on-time is nonzero and at least the period stays high for the whole period. This includes a period of 0, where the count holds at 0.
- R7: A window that runs past the end of the period is cut off at the wrap. It does not continue into the start of the next period.
- R8: A channel whose bit in ch_enable is 0 drives a low output regardless of its settings.
- R9: When frame-sync and line-sync rise in the same cycle, the frame realignment wins and the count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_sync | input | 1 | Asynchronous line-rate counting clock |
| frame_sync | input | 1 | Asynchronous frame-rate realignment input |
| period_cfg | input | CNT_W | Common PWM period in line ticks |
| delay_cfg | input | NUM_CH*CNT_W | Per-channel delay, channel i at bits [i*CNT_W +: CNT_W] |
| on_cfg | input | NUM_CH*CNT_W | Per-channel on-time, same packing as delay_cfg |
| ch_enable | input | NUM_CH | Per-channel enable, bit i for channel i |
| dim_out | output | NUM_CH | Per-channel dimming gate, registered |

## Verification
The bench targets the window edges: the tick where a channel turns on and the tick just past its on-time. An off-by-one comparator would light a channel one tick early or late. It then drives a count past the period. A counter without the wrap would leave the channel dark on its second pulse in the frame, and a window that wrapped would light it at count 0. It also covers on-time values of zero and of at least the period, a period of zero, and a frame sync in the middle of a period, which exposes a design that ignores realignment. A frame edge coincident with a line edge shows whether the increment wrongly takes priority. Finally, it drives line activity before any frame sync and per-channel enables, to catch outputs that leak while the bank should be dark.

// File: rtl/sync_pwm_pkg.sv
package sync_pwm_pkg;
  typedef enum logic {
    BANK_IDLE = 1'b0,
    BANK_RUN  = 1'b1
  } bank_state_e;
endpackage

// File: rtl/sync_edge_detect.sv
module sync_edge_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;

  // R2: an edge is reported for a single cycle only
  p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/line_tick_counter.sv
module line_tick_counter
  import sync_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_rise,
  input  logic             frame_rise,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             running
);
  bank_state_e state_q;
  logic [CNT_W:0] next_val;

  assign next_val = {1'b0, count} + 1'b1;
  assign running  = (state_q == BANK_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BANK_IDLE;
      count   <= '0;
    end else if (frame_rise) begin
      state_q <= BANK_RUN;
      count   <= '0;
    end else if (line_rise && running) begin
      if (next_val >= {1'b0, period}) count <= '0;
      else                            count <= next_val[CNT_W-1:0];
    end
  end

  // R2 / R9: frame edge realigns to zero even with a coincident line edge
  p_frame_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rise |=> (count == '0) && running);

  // R4: below the period a line tick advances the count by exactly one
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && line_rise && !frame_rise && ({1'b0, count} + 1'b1 < {1'b0, period}))
      |=> count == $past(count) + 1'b1);

  // R1: no counting before the first frame edge
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !frame_rise) |=> $stable(count) && !running);
endmodule

// File: rtl/dim_channel.sv
module dim_channel #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             enable,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] delay,
  input  logic [CNT_W-1:0] on_time,
  output logic             dim
);
  logic [CNT_W:0] win_end;
  logic           in_window;
  logic           full_on;
  logic           lit;

  assign win_end   = {1'b0, delay} + {1'b0, on_time};
  assign in_window = (count >= delay) && ({1'b0, count} < win_end);
  assign full_on   = (on_time >= period);
  assign lit       = running && enable && (on_time != '0) && (full_on || in_window);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dim <= 1'b0;
    else        dim <= lit;
  end

  // R8: a disabled channel is dark on the next cycle
  p_off_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !dim);

  // R5: zero on-time never lights the channel
  p_zero_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (on_time == '0) |=> !dim);

  // R6: on-time covering the period keeps the channel lit
  p_full_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && enable && (on_time != '0) && (on_time >= period)) |=> dim);
endmodule

// File: rtl/sync_pwm_dimmer.sv
module sync_pwm_dimmer #(
  parameter int unsigned NUM_CH      = 16,
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    line_sync,
  input  logic                    frame_sync,
  input  logic [CNT_W-1:0]        period_cfg,
  input  logic [NUM_CH*CNT_W-1:0] delay_cfg,
  input  logic [NUM_CH*CNT_W-1:0] on_cfg,
  input  logic [NUM_CH-1:0]       ch_enable,
  output logic [NUM_CH-1:0]       dim_out
);
  logic             line_rise;
  logic             frame_rise;
  logic [CNT_W-1:0] count;
  logic             running;

  sync_edge_detect #(.STAGES(SYNC_STAGES)) u_line_edge (
    .clk(clk), .rst_n(rst_n), .async_in(line_sync), .rise(line_rise)
  );

  sync_edge_detect #(.STAGES(SYNC_STAGES)) u_frame_edge (
    .clk(clk), .rst_n(rst_n), .async_in(frame_sync), .rise(frame_rise)
  );

  line_tick_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .line_rise(line_rise), .frame_rise(frame_rise),
    .period(period_cfg), .count(count), .running(running)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      dim_channel #(.CNT_W(CNT_W)) u_ch (
        .clk(clk), .rst_n(rst_n), .running(running), .enable(ch_enable[i]),
        .count(count), .period(period_cfg),
        .delay(delay_cfg[i*CNT_W +: CNT_W]), .on_time(on_cfg[i*CNT_W +: CNT_W]),
        .dim(dim_out[i])
      );
    end
  endgenerate

  // R1: the bank stays dark until realigned by a frame edge
  p_dark_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> dim_out == '0);
endmodule

// File: tb/sync_pwm_dimmer_test.sv
module sync_pwm_dimmer_test;
  localparam int NCH = 16;
  localparam int CW  = 12;

  typedef struct packed {
    logic [11:0] p;
    logic [11:0] d;
    logic [11:0] on;
    logic [7:0]  k;
    logic        e;
  } vec_t;

  // period, delay, on-time, line ticks after frame, expected level
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{12'd10, 12'd2, 12'd3,  8'd0,  1'b0},  // R3 before window
    '{12'd10, 12'd2, 12'd3,  8'd2,  1'b1},  // R3 window start
    '{12'd10, 12'd2, 12'd3,  8'd4,  1'b1},  // R3 last lit tick
    '{12'd10, 12'd2, 12'd3,  8'd5,  1'b0},  // R3 window end
    '{12'd10, 12'd2, 12'd3,  8'd12, 1'b1},  // R4 second period
    '{12'd10, 12'd0, 12'd0,  8'd0,  1'b0},  // R5 zero on-time
    '{12'd10, 12'd0, 12'd10, 8'd7,  1'b1},  // R6 full on
    '{12'd10, 12'd8, 12'd5,  8'd9,  1'b1},  // R7 inside cut window
    '{12'd10, 12'd8, 12'd5,  8'd10, 1'b0},  // R7 no spill past wrap
    '{12'd6,  12'd0, 12'd2,  8'd1,  1'b1},  // R4 short period
    '{12'd6,  12'd0, 12'd2,  8'd6,  1'b1},  // R4 wrapped to zero
    '{12'd6,  12'd0, 12'd2,  8'd8,  1'b0},  // R4 wrapped past window
    '{12'd0,  12'd3, 12'd1,  8'd5,  1'b1}   // R6 period zero
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 line_sync = 1'b0;
  logic                 frame_sync = 1'b0;
  logic [CW-1:0]        period_cfg = '0;
  logic [NCH*CW-1:0]    delay_cfg = '0;
  logic [NCH*CW-1:0]    on_cfg = '0;
  logic [NCH-1:0]       ch_enable = '0;
  logic [NCH-1:0]       dim_out;

  int checks = 0;
  int failures = 0;
  string tags [NV];

  always #5 clk = ~clk;

  sync_pwm_dimmer uut (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .frame_sync(frame_sync),
    .period_cfg(period_cfg), .delay_cfg(delay_cfg), .on_cfg(on_cfg),
    .ch_enable(ch_enable), .dim_out(dim_out)
  );

  task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic line_pulse();
    line_sync = 1'b1; wait_clks(4);
    line_sync = 1'b0; wait_clks(4);
  endtask

  task automatic frame_pulse();
    frame_sync = 1'b1; wait_clks(4);
    frame_sync = 1'b0; wait_clks(4);
  endtask

  task automatic both_pulse();
    frame_sync = 1'b1; line_sync = 1'b1; wait_clks(4);
    frame_sync = 1'b0; line_sync = 1'b0; wait_clks(4);
  endtask

  task automatic set_all(input logic [CW-1:0] p, input logic [CW-1:0] d, input logic [CW-1:0] on);
    period_cfg = p;
    delay_cfg  = {NCH{d}};
    on_cfg     = {NCH{on}};
  endtask

  initial begin
    tags = '{"R3", "R3", "R3", "R3", "R4", "R5", "R6", "R7", "R7", "R4", "R4", "R4", "R6"};
    wait_clks(3);
    check("R1 in reset", dim_out, '0);
    ch_enable = '1;
    set_all(12'd10, 12'd0, 12'd10);
    rst_n = 1'b1;
    wait_clks(2);
    line_pulse(); line_pulse(); line_pulse();
    check("R1 dark before first frame", dim_out, '0);
    frame_pulse();
    check("R1 lit after first frame", dim_out, '1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      set_all(VECS[v].p, VECS[v].d, VECS[v].on);
      frame_pulse();
      for (int t = 0; t < int'(VECS[v].k); t++) line_pulse();
      check(tags[v], dim_out, VECS[v].e ? '1 : '0);
    end

    // R8: per-channel enable
    set_all(12'd10, 12'd0, 12'd10);
    ch_enable = 16'h00FF;
    frame_pulse();
    check("R8 enable mask", dim_out, 16'h00FF);
    ch_enable = '1;

    // R2: mid-period realignment
    set_all(12'd10, 12'd2, 12'd3);
    frame_pulse();
    line_pulse(); line_pulse(); line_pulse();
    check("R2 lit before realign", dim_out, '1);
    frame_pulse();
    check("R2 realigned to zero", dim_out, '0);
    line_pulse(); line_pulse();
    check("R2 counts from zero", dim_out, '1);

    // R9: coincident frame and line edges
    set_all(12'd10, 12'd0, 12'd1);
    frame_pulse();
    for (int t = 0; t < 5; t++) line_pulse();
    check("R9 dark at count five", dim_out, '0);
    both_pulse();
    check("R9 frame wins", dim_out, '1);

    // R3: staggered channels, one lit per tick
    period_cfg = 12'd16;
    for (int c = 0; c < NCH; c++) begin
      delay_cfg[c*CW +: CW] = CW'(c);
      on_cfg[c*CW +: CW]    = 12'd1;
    end
    frame_pulse();
    for (int k = 0; k < NCH; k++) begin
      check("R3 staggered", dim_out, NCH'(1) << k);
      line_pulse();
    end
    check("R4 staggered wrap", dim_out, NCH'(1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule